// File: doc/BRIEF.md
# Macroblock Decode Accelerator Flag Register

This block is the single shared flag word through which a processor steers a three-stage macroblock decode accelerator: an inverse-transform stage, a motion compensation stage and a colour conversion stage. The processor reaches the word through a plain byte-addressed read/write port at a fixed offset. The stages connect through done pulses, read strobes and a start pulse. The datapaths are not part of this block.

Each of the three stages reports finished output through a sticky ready flag. The flag is set by the stage's one-cycle done pulse and cleared when software strobes the matching data port. Software starts motion compensation by moving a control bit from 0 to 1 and back to 0. The block turns the rising edge into one start cycle and latches the macroblock type with it. A start edge that arrives while motion compensation is still running is refused and recorded in an error flag. The block also tracks which block of the macroblock is in flight, in the order U, V, Y, Y, and keeps a parity count of converted RGB blocks that software consults while handling luma.

Top module: `mbdec_flag_csr`

## Requirements
- R1: While reset is asserted and after it is released, the flag word reads all zeros, `mc_start` is 0, `mc_inter` is 0 (intra), and `blk_pos` is 0 (U).
- R2: Bit 11 (inverse-transform output ready), bit 10 (reconstructed YUV ready) and bit 9 (RGB ready) are each set by a one-cycle pulse on `idct_done`, `yuv_done` and `rgb_done` respectively. Each stays set until its strobe `idct_rd`, `yuv_rd` or `rgb_rd` clears it, and a strobe affects only its own bit.
- R3: When a done pulse and the matching read strobe fall in the same cycle, the ready bit is 1 afterwards.
- R4: A write to the flag word with bit 12 at 1, while the previously written bit 12 was 0, drives `mc_start` high for exactly one cycle, the cycle after the write. A write that keeps bit 12 at 1 gives no pulse.
- R5: Bit 13 (macroblock type, 0 intra, 1 inter) is captured only on an accepted start edge. It then drives `mc_inter` and reads back in bit 13. Writes to bit 13 without an accepted edge leave it unchanged.
- R6: Bit 16 (motion compensation busy) is set by an accepted start and cleared by a pulse on `mc_done`.
- R7: A start edge while busy, without `mc_done` in the same cycle, gives no `mc_start` pulse and sets bit 17 (overrun error). Bit 17 is cleared only by writing 1 to it. A start edge in the same cycle as `mc_done` is accepted.
- R8: The block position in bits 15:14 and on `blk_pos` starts at 0 (U). It advances by one on each `yuv_done` through 0 U, 1 V, 2 Y, 3 Y and wraps from 3 to 0. `blk_luma` is high at positions 2 and 3.
- R9: Bit 20 (RGB block count parity) toggles on each `rgb_done` pulse.
- R10: Writes cannot change read-only bits 9, 10, 11, 14, 15, 16 and 20. Reserved bits read 0. Reads at any other address return 0, and writes at any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_sel | input | 1 | Processor access select |
| cpu_wr | input | 1 | 1 write, 0 read |
| cpu_addr | input | 12 | Byte address; flag word at 0x200 |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid in the cycle of a read access |
| idct_done | input | 1 | Inverse-transform stage output finished (pulse) |
| yuv_done | input | 1 | Reconstructed block finished (pulse) |
| rgb_done | input | 1 | Colour conversion finished (pulse) |
| idct_rd | input | 1 | Software read strobe of the inverse-transform data port |
| yuv_rd | input | 1 | Software read strobe of the YUV data port |
| rgb_rd | input | 1 | Software read strobe of the RGB data port |
| mc_done | input | 1 | Motion compensation finished (pulse) |
| mc_start | output | 1 | One-cycle start to motion compensation |
| mc_inter | output | 1 | Latched macroblock type, 1 inter |
| blk_pos | output | 2 | Current block position in the macroblock |
| blk_luma | output | 1 | Current block is a luma block |

## Verification
Two pairs of events can coincide. A stage's done pulse can meet software's read strobe for the same ready bit. A refused start edge can meet the `mc_done` that ends the running job. The bench drives both members of each pair on the same clock edge. It then expects the ready bit to remain 1, and it expects the start to be accepted with a pulse on `mc_start` and no overrun error.

// File: rtl/mbdec_csr_pkg.sv
package mbdec_csr_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned NUM_STAGES = 3;

  // Stage indices into the ready-flag vector
  localparam int unsigned STG_IDCT = 0;
  localparam int unsigned STG_YUV  = 1;
  localparam int unsigned STG_RGB  = 2;

  // Bit positions inside the flag word
  localparam int unsigned B_RGB_RDY  = 9;
  localparam int unsigned B_YUV_RDY  = 10;
  localparam int unsigned B_IDCT_RDY = 11;
  localparam int unsigned B_MC_GO    = 12;
  localparam int unsigned B_MB_TYPE  = 13;
  localparam int unsigned B_POS_LO   = 14;
  localparam int unsigned B_POS_HI   = 15;
  localparam int unsigned B_MC_BUSY  = 16;
  localparam int unsigned B_OVERRUN  = 17;
  localparam int unsigned B_RGB_PAR  = 20;

  typedef enum logic [1:0] {
    BLK_U  = 2'd0,
    BLK_V  = 2'd1,
    BLK_Y0 = 2'd2,
    BLK_Y1 = 2'd3
  } blk_pos_e;

  // Flag-word bit for each stage's ready flag
  function automatic int unsigned rdy_bit(input int unsigned stg);
    case (stg)
      STG_IDCT: rdy_bit = B_IDCT_RDY;
      STG_YUV:  rdy_bit = B_YUV_RDY;
      default:  rdy_bit = B_RGB_RDY;
    endcase
  endfunction

endpackage

// File: rtl/mbdec_ready_flag.sv
module mbdec_ready_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_strobe,
  output logic flag
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  // Set dominates a clear in the same cycle
  always_comb begin
    flag_en = set_pulse | clr_strobe;
    flag_d  = set_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> flag);

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_strobe) |=> flag);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe && !set_pulse) |=> !flag);

endmodule

// File: rtl/mbdec_mc_launch.sv
module mbdec_mc_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic go_wr,
  input  logic type_wr,
  input  logic err_w1c,
  input  logic mc_done,
  output logic go_level,
  output logic mc_start,
  output logic mc_inter,
  output logic busy,
  output logic overrun
);

  logic go_q, go_d;
  logic start_q, start_d;
  logic type_q, type_d;
  logic busy_q, busy_d;
  logic err_q, err_d;
  logic edge_seen;
  logic accept;
  logic refuse;

  always_comb begin
    edge_seen = wr_hit & go_wr & ~go_q;
    accept    = edge_seen & (~busy_q | mc_done);
    refuse    = edge_seen & busy_q & ~mc_done;

    go_d    = wr_hit ? go_wr : go_q;
    start_d = accept;
    type_d  = accept ? type_wr : type_q;

    if (accept) begin
      busy_d = 1'b1;
    end else if (mc_done) begin
      busy_d = 1'b0;
    end else begin
      busy_d = busy_q;
    end

    if (refuse) begin
      err_d = 1'b1;
    end else if (wr_hit && err_w1c) begin
      err_d = 1'b0;
    end else begin
      err_d = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      start_q <= 1'b0;
      type_q  <= 1'b0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      go_q    <= go_d;
      start_q <= start_d;
      type_q  <= type_d;
      busy_q  <= busy_d;
      err_q   <= err_d;
    end
  end

  assign go_level = go_q;
  assign mc_start = start_q;
  assign mc_inter = type_q;
  assign busy     = busy_q;
  assign overrun  = err_q;

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mc_start |=> !mc_start);

  p_start_marks_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mc_start |-> busy);

  p_type_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_start |-> $stable(mc_inter));

  p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(busy) && !mc_start));

endmodule

// File: rtl/mbdec_blk_track.sv
module mbdec_blk_track
  import mbdec_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blk_adv,
  input  logic       rgb_adv,
  output blk_pos_e   pos,
  output logic       luma,
  output logic       rgb_par
);

  blk_pos_e pos_q, pos_d;
  logic     par_q, par_d;

  always_comb begin
    pos_d = pos_q;
    if (blk_adv) begin
      case (pos_q)
        BLK_U:   pos_d = BLK_V;
        BLK_V:   pos_d = BLK_Y0;
        BLK_Y0:  pos_d = BLK_Y1;
        default: pos_d = BLK_U;
      endcase
    end
    par_d = par_q ^ rgb_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= BLK_U;
      par_q <= 1'b0;
    end else begin
      if (blk_adv) begin
        pos_q <= pos_d;
      end
      if (rgb_adv) begin
        par_q <= par_d;
      end
    end
  end

  assign pos     = pos_q;
  assign luma    = (pos_q == BLK_Y0) || (pos_q == BLK_Y1);
  assign rgb_par = par_q;

  p_pos_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_adv |=> (pos == blk_pos_e'($past(pos) + 2'd1)));

  p_pos_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_adv |=> $stable(pos));

  p_par_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_adv |=> (rgb_par != $past(rgb_par)));

endmodule

// File: rtl/mbdec_flag_csr.sv
module mbdec_flag_csr
  import mbdec_csr_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]  FLAG_OFS = 12'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  input  logic              idct_done,
  input  logic              yuv_done,
  input  logic              rgb_done,
  input  logic              idct_rd,
  input  logic              yuv_rd,
  input  logic              rgb_rd,
  input  logic              mc_done,
  output logic              mc_start,
  output logic              mc_inter,
  output logic [1:0]        blk_pos,
  output logic              blk_luma
);

  logic                  hit;
  logic                  wr_hit;
  logic                  rd_hit;
  logic [NUM_STAGES-1:0] done_v;
  logic [NUM_STAGES-1:0] rd_v;
  logic [NUM_STAGES-1:0] rdy_v;
  logic                  go_level;
  logic                  busy;
  logic                  overrun;
  logic                  rgb_par;
  blk_pos_e              pos;
  logic [WORD_W-1:0]     flag_word;
  logic                  wdata_unused;

  assign hit    = cpu_sel && (cpu_addr == FLAG_OFS);
  assign wr_hit = hit && cpu_wr;
  assign rd_hit = hit && !cpu_wr;

  assign done_v = {rgb_done, yuv_done, idct_done};
  assign rd_v   = {rgb_rd, yuv_rd, idct_rd};

  // Bits the write path never looks at
  assign wdata_unused = ^{cpu_wdata[WORD_W-1:B_OVERRUN+1],
                          cpu_wdata[B_MC_BUSY:B_POS_LO],
                          cpu_wdata[B_MC_GO-1:0]};

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    mbdec_ready_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_pulse  (done_v[s]),
      .clr_strobe (rd_v[s]),
      .flag       (rdy_v[s])
    );
  end

  mbdec_mc_launch u_launch (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (wr_hit),
    .go_wr    (cpu_wdata[B_MC_GO]),
    .type_wr  (cpu_wdata[B_MB_TYPE]),
    .err_w1c  (cpu_wdata[B_OVERRUN]),
    .mc_done  (mc_done),
    .go_level (go_level),
    .mc_start (mc_start),
    .mc_inter (mc_inter),
    .busy     (busy),
    .overrun  (overrun)
  );

  mbdec_blk_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .blk_adv (yuv_done),
    .rgb_adv (rgb_done),
    .pos     (pos),
    .luma    (blk_luma),
    .rgb_par (rgb_par)
  );

  always_comb begin
    flag_word = '0;
    for (int s = 0; s < NUM_STAGES; s++) begin
      flag_word[rdy_bit(s)] = rdy_v[s];
    end
    flag_word[B_MC_GO]            = go_level;
    flag_word[B_MB_TYPE]          = mc_inter;
    flag_word[B_POS_HI:B_POS_LO]  = pos;
    flag_word[B_MC_BUSY]          = busy;
    flag_word[B_OVERRUN]          = overrun;
    flag_word[B_RGB_PAR]          = rgb_par;
  end

  assign cpu_rdata = rd_hit ? flag_word : '0;
  assign blk_pos   = pos;

  p_miss_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (cpu_rdata == '0));

  p_luma_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_luma |-> blk_pos[1]);

endmodule

// File: tb/test_mbdec_flag_csr.sv
module test_mbdec_flag_csr;

  localparam time TCLK = 20ns;
  localparam logic [11:0] FLAG_A = 12'h200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_sel, cpu_wr;
  logic [11:0] cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        idct_done, yuv_done, rgb_done;
  logic        idct_rd, yuv_rd, rgb_rd;
  logic        mc_done, mc_start, mc_inter, blk_luma;
  logic [1:0]  blk_pos;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(TCLK/2) clk = ~clk;

  mbdec_flag_csr i_mbdec_flag_csr (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .idct_done(idct_done), .yuv_done(yuv_done), .rgb_done(rgb_done),
    .idct_rd(idct_rd), .yuv_rd(yuv_rd), .rgb_rd(rgb_rd),
    .mc_done(mc_done), .mc_start(mc_start), .mc_inter(mc_inter),
    .blk_pos(blk_pos), .blk_luma(blk_luma)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cpu_sel = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
    idct_done = 0; yuv_done = 0; rgb_done = 0;
    idct_rd = 0; yuv_rd = 0; rgb_rd = 0; mc_done = 0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_sel = 0;
  endtask

  // which: 0 idct, 1 yuv, 2 rgb; kind: 0 done, 1 read strobe, 2 both
  task automatic stage_pulse(input int which, input int kind);
    @(negedge clk);
    if (kind != 1) begin
      if (which == 0) idct_done = 1; else if (which == 1) yuv_done = 1; else rgb_done = 1;
    end
    if (kind != 0) begin
      if (which == 0) idct_rd = 1; else if (which == 1) yuv_rd = 1; else rgb_rd = 1;
    end
    @(negedge clk);
    idct_done = 0; yuv_done = 0; rgb_done = 0;
    idct_rd = 0; yuv_rd = 0; rgb_rd = 0;
  endtask

  task automatic pulse_mc_done();
    @(negedge clk); mc_done = 1;
    @(negedge clk); mc_done = 0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    cpu_sel = 1; cpu_addr = FLAG_A; #1;
    check("R1 word in reset", cpu_rdata, 32'h0);
    cpu_sel = 0;
    rst_n = 1;
    cpu_read(FLAG_A, r);
    check("R1 word after reset", r, 32'h0);
    check("R1 outputs after reset", {28'h0, mc_start, mc_inter, blk_pos}, 32'h0);
    check("R1 luma after reset", {31'h0, blk_luma}, 32'h0);
  endtask

  task automatic t_ready_flags();
    logic [31:0] r;
    int bits[3] = '{11, 10, 9};
    for (int k = 0; k < 3; k++) begin
      apply_reset();
      stage_pulse(k, 0);
      repeat (2) @(negedge clk);
      cpu_read(FLAG_A, r);
      check($sformatf("R2 stage %0d flag set and sticky", k),
            r & 32'h0E00, 32'h1 << bits[k]);
      for (int j = 0; j < 3; j++) begin
        if (j != k) stage_pulse(j, 1);
      end
      cpu_read(FLAG_A, r);
      check($sformatf("R2 stage %0d other strobes", k), r & 32'h0E00, 32'h1 << bits[k]);
      stage_pulse(k, 1);
      cpu_read(FLAG_A, r);
      check($sformatf("R2 stage %0d cleared by strobe", k), r & 32'h0E00, 32'h0);
    end
  endtask

  task automatic t_collide();
    logic [31:0] r;
    apply_reset();
    stage_pulse(0, 2);
    cpu_read(FLAG_A, r);
    check("R3 done with strobe from clear", r & 32'h0E00, 32'h0800);
    stage_pulse(2, 2);
    cpu_read(FLAG_A, r);
    check("R3 done with strobe while set", r & 32'h0E00, 32'h0A00);
  endtask

  task automatic t_mc_start();
    logic [31:0] r;
    apply_reset();
    cpu_write(FLAG_A, 32'h0000_0000);
    check("R4 no pulse on zero write", {31'h0, mc_start}, 32'h0);
    cpu_write(FLAG_A, 32'h0000_1000);
    check("R4 pulse after rising write", {31'h0, mc_start}, 32'h1);
    @(negedge clk);
    check("R4 pulse lasts one cycle", {31'h0, mc_start}, 32'h0);
    cpu_read(FLAG_A, r);
    check("R6 busy after start", r & 32'h0001_0000, 32'h0001_0000);
    pulse_mc_done();
    cpu_write(FLAG_A, 32'h0000_1000);
    check("R4 held level gives no pulse", {31'h0, mc_start}, 32'h0);
    cpu_read(FLAG_A, r);
    check("R6 busy cleared by done", r & 32'h0001_0000, 32'h0);
  endtask

  task automatic t_mc_type();
    logic [31:0] r;
    apply_reset();
    cpu_write(FLAG_A, 32'h0000_3000);
    check("R5 inter latched on edge", {31'h0, mc_inter}, 32'h1);
    pulse_mc_done();
    cpu_write(FLAG_A, 32'h0000_0000);
    cpu_read(FLAG_A, r);
    check("R5 type kept without edge", r & 32'h0000_2000, 32'h0000_2000);
    cpu_write(FLAG_A, 32'h0000_1000);
    check("R5 intra latched on edge", {31'h0, mc_inter}, 32'h0);
    pulse_mc_done();
  endtask

  task automatic t_overrun();
    logic [31:0] r;
    apply_reset();
    cpu_write(FLAG_A, 32'h0000_1000);
    cpu_write(FLAG_A, 32'h0000_0000);
    cpu_write(FLAG_A, 32'h0000_3000);
    check("R7 no pulse while busy", {31'h0, mc_start}, 32'h0);
    check("R7 type not latched when refused", {31'h0, mc_inter}, 32'h0);
    cpu_read(FLAG_A, r);
    check("R7 overrun flagged", r & 32'h0003_0000, 32'h0003_0000);
    cpu_write(FLAG_A, 32'h0000_0000);
    cpu_read(FLAG_A, r);
    check("R7 writing 0 keeps error", r & 32'h0002_0000, 32'h0002_0000);
    cpu_write(FLAG_A, 32'h0002_0000);
    cpu_read(FLAG_A, r);
    check("R7 write 1 clears error", r & 32'h0002_0000, 32'h0);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = FLAG_A; cpu_wdata = 32'h0000_1000; mc_done = 1;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0; mc_done = 0;
    check("R7 edge with done accepted", {31'h0, mc_start}, 32'h1);
    cpu_read(FLAG_A, r);
    check("R7 no error when done coincides", r & 32'h0003_0000, 32'h0001_0000);
  endtask

  task automatic t_block_order();
    logic [31:0] r;
    logic [1:0] exp_pos;
    apply_reset();
    for (int i = 0; i < 5; i++) begin
      exp_pos = 2'(i);
      cpu_read(FLAG_A, r);
      check($sformatf("R8 position step %0d", i), (r >> 14) & 32'h3, {30'h0, exp_pos});
      check($sformatf("R8 port step %0d", i), {29'h0, blk_luma, blk_pos},
            {29'h0, exp_pos[1], exp_pos});
      stage_pulse(1, 2);
    end
  endtask

  task automatic t_rgb_count();
    logic [31:0] r;
    apply_reset();
    stage_pulse(2, 0);
    cpu_read(FLAG_A, r);
    check("R9 count after one", r & 32'h0010_0000, 32'h0010_0000);
    stage_pulse(2, 0);
    cpu_read(FLAG_A, r);
    check("R9 count after two", r & 32'h0010_0000, 32'h0);
  endtask

  task automatic t_ro_writes();
    logic [31:0] r;
    apply_reset();
    cpu_write(FLAG_A, 32'hFFFD_EFFF);
    cpu_read(FLAG_A, r);
    check("R10 read-only and reserved ignore writes", r, 32'h0);
    cpu_write(12'h204, 32'h0000_1000);
    check("R10 write elsewhere no start", {31'h0, mc_start}, 32'h0);
    stage_pulse(0, 0);
    cpu_read(12'h204, r);
    check("R10 read elsewhere is zero", r, 32'h0);
    cpu_read(FLAG_A, r);
    check("R10 flag word after stray write", r, 32'h0000_0800);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    t_reset();
    t_ready_flags();
    t_collide();
    t_mc_start();
    t_mc_type();
    t_overrun();
    t_block_order();
    t_rgb_count();
    t_ro_writes();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule